// File: doc/BRIEF.md
# ECP Control and Indexed Configuration Registers

This block holds the control state of an extended-capabilities parallel port as seen by the CPU. An extended control register carries a three-bit operating mode, a DMA enable, an error-interrupt mask and a service bit. Together these drive the DMA request, its output enable and the current mode. The error line is active low. It passes through a two-flop synchronizer and then into a small state machine. That machine raises a one-cycle interrupt pulse on a falling edge. It also raises one when software clears the mask while the line is still low, so an event that arrives between a read and a write of the register is not lost.

A second pair of registers, an index and a data window, gives access to four indirectly addressed configuration registers. The index holds a three-bit second-level offset. Only offsets 0, 2, 4 and 5 reach storage. Both registers answer only while the external configuration enable is high. The indirect registers keep their values until reset.

The error state machine has two states. `LINE_IDLE` means the synchronized line is high. `LINE_FAULT` means it is low. The transition `FALL` (`LINE_IDLE` to `LINE_FAULT`) fires the interrupt when the mask is 0. The transition `RISE` (`LINE_FAULT` to `LINE_IDLE`) never fires. The self-loop `RELEASE` in `LINE_FAULT` fires when the mask changed from 1 to 0 on the previous clock edge.

Top module: `ecp_ctrl_regs`

## Requirements
- R1: After reset:
  - the extended control register reads 00h, and `mode` is 000;
  - `dma_req_oe` and `dma_req` are 0, and no interrupt pulse occurs;
  - the index reads 00h, and every indirect register reads 00h.
- R2: Bus address encoding:
  - 0 selects the extended control register, 1 the index and 2 the data window;
  - address 3 reads 00h.
- R3: Bits 7:5 of the extended control register are the mode, and `mode` follows them:
  - 000 standard, 001 PS/2, 010 parallel FIFO, 011 ECP FIFO, 100 EPP, 110 FIFO test, 111 configuration.
  - A write carrying 101 leaves the mode unchanged, while the other fields of that write still take effect.
- R4: Bits 1:0 of the extended control register read as 0 whatever is written.
- R5: With the mask (bit 4) at 0, each high-to-low transition of `fault_n` produces exactly one single-cycle `irq_pulse`. A low-to-high transition produces none.
- R6: With the mask at 1, a falling edge of `fault_n` produces no pulse.
- R7: Writing the mask from 1 to 0 while `fault_n` is low produces exactly one pulse. Doing the same while `fault_n` is high produces none.
- R8: With the DMA enable (bit 3) at 0, `dma_req_oe` and `dma_req` are 0. With it at 1, `dma_req_oe` is 1 and `dma_req` is the inverse of the service bit (bit 2).
- R9: A one-cycle `svc_set` sets the service bit to 1. A CPU write can also set or clear it, and `svc_set` wins in the same cycle.
- R10: The index stores bits 2:0 of a write. Its bits 7:3 read as 0.
- R11: Through the data window, offsets 0, 2, 4 and 5 each read back their own last written byte.
- R12: At offsets 1, 3, 6 and 7, a data write changes no indirect register, and a data read returns 00h.
- R13: While `cfg_en` is 0, writes to the index and data window are ignored, and reads of them return 00h. Their contents are kept and are visible again once `cfg_en` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select (0 control, 1 index, 2 data) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read data is combinational) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| cfg_en | input | 1 | Enables the index and data window |
| fault_n | input | 1 | Asynchronous active-low error line |
| svc_set | input | 1 | Sets the service bit |
| dma_req | output | 1 | DMA request |
| dma_req_oe | output | 1 | Output enable of the DMA request (0 means tri-stated) |
| irq_pulse | output | 1 | One-cycle error interrupt |
| mode | output | 3 | Current operating mode |

## Verification
The interrupt path is tested with several error-line patterns:
- a falling edge with the mask clear, and the matching rising edge;
- a falling edge under the mask;
- a mask release while the line is low, and a mask release while it is high.

Together these separate edge detection from level detection, and they isolate the release path. Every offset of the data window is exercised. Distinct data values per offset expose aliasing between slots. Writes at the unsupported offsets, followed by readback of all four slots, expose stray decodes. The cycle with `cfg_en` low checks that the window is gated and that its contents survive.

// File: rtl/ecp_pkg.sv
package ecp_pkg;

    typedef enum logic [2:0] {
        MODE_STD     = 3'b000,
        MODE_PS2     = 3'b001,
        MODE_PPFIFO  = 3'b010,
        MODE_ECPFIFO = 3'b011,
        MODE_EPP     = 3'b100,
        MODE_RSVD    = 3'b101,
        MODE_TEST    = 3'b110,
        MODE_CFG     = 3'b111
    } ecp_mode_e;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_IDX  = 2'd1,
        SEL_DATA = 2'd2,
        SEL_NONE = 2'd3
    } bus_sel_e;

    typedef enum logic {
        LINE_IDLE  = 1'b0,
        LINE_FAULT = 1'b1
    } err_state_e;

    localparam int NUM_SLOTS = 4;
    localparam int OFF_W     = 3;

    // Bit positions inside the extended control register.
    localparam int BIT_MASK = 4;
    localparam int BIT_DMA  = 3;
    localparam int BIT_SVC  = 2;

    function automatic logic [OFF_W-1:0] slot_offset(input int idx);
        case (idx)
            0:       return 3'd0;
            1:       return 3'd2;
            2:       return 3'd4;
            default: return 3'd5;
        endcase
    endfunction

endpackage

// File: rtl/ecp_sync.sv
module ecp_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RESET_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ecp_err_irq.sv
module ecp_err_irq
    import ecp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_n,
    input  logic mask,
    output logic irq_pulse
);
    err_state_e state, state_nxt;
    logic       mask_prev;
    logic       fire;

    // Next-state and fire logic.
    always_comb begin
        state_nxt = state;
        fire      = 1'b0;
        unique case (state)
            LINE_IDLE: begin
                if (!line_n) begin
                    state_nxt = LINE_FAULT;   // FALL
                    fire      = !mask;
                end
            end
            LINE_FAULT: begin
                if (line_n) begin
                    state_nxt = LINE_IDLE;    // RISE
                end else if (mask_prev && !mask) begin
                    fire      = 1'b1;         // RELEASE
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= LINE_IDLE;
            mask_prev <= 1'b0;
        end else begin
            state     <= state_nxt;
            mask_prev <= mask;
        end
    end

    // Registered output.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_pulse <= 1'b0;
        else        irq_pulse <= fire;
    end

    // R5
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R6
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask && mask_prev) |=> !irq_pulse);

    // R5
    rise_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LINE_FAULT && line_n) |=> !irq_pulse);
endmodule

// File: rtl/ecp_index_regs.sv
module ecp_index_regs
    import ecp_pkg::*;
#(
    parameter logic [NUM_SLOTS*8-1:0] SLOT_RESET = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic             data_wr,
    input  logic [7:0]       wdata,
    output logic [OFF_W-1:0] idx_q,
    output logic [7:0]       data_rdata
);
    logic [NUM_SLOTS-1:0]   hit;
    logic [7:0]             slot_q [NUM_SLOTS];
    logic [NUM_SLOTS*8-1:0] slots_flat;
    logic                   hit_any;

    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_wr) idx_q <= wdata[OFF_W-1:0];
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam logic [OFF_W-1:0] OFF = slot_offset(g);
        assign hit[g] = (idx_q == OFF);

        always_ff @(posedge clk) begin
            if (!rst_n)                slot_q[g] <= SLOT_RESET[g*8 +: 8];
            else if (data_wr && hit[g]) slot_q[g] <= wdata;
        end

        assign slots_flat[g*8 +: 8] = slot_q[g];
    end

    assign hit_any = |hit;

    always_comb begin
        data_rdata = 8'h00;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (hit[i]) data_rdata = data_rdata | slot_q[i];
        end
    end

    // R12
    bad_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !hit_any) |=> $stable(slots_flat));

    // R11
    one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
endmodule

// File: rtl/ecp_ctrl_regs.sv
module ecp_ctrl_regs
    import ecp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       cfg_en,
    input  logic       fault_n,
    input  logic       svc_set,
    output logic       dma_req,
    output logic       dma_req_oe,
    output logic       irq_pulse,
    output logic [2:0] mode
);
    ecp_mode_e         mode_q;
    logic              mask_q, dma_q, svc_q;
    logic              ctrl_wr, idx_wr, data_wr;
    logic              fault_sync;
    logic [OFF_W-1:0]  idx_q;
    logic [7:0]        data_rdata;
    bus_sel_e          sel;

    assign sel     = bus_sel_e'(bus_addr);
    assign ctrl_wr = bus_wr && (sel == SEL_CTRL);
    assign idx_wr  = bus_wr && cfg_en && (sel == SEL_IDX);
    assign data_wr = bus_wr && cfg_en && (sel == SEL_DATA);

    // Extended control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_STD;
            mask_q <= 1'b0;
            dma_q  <= 1'b0;
            svc_q  <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                if (ecp_mode_e'(bus_wdata[7:5]) != MODE_RSVD)
                    mode_q <= ecp_mode_e'(bus_wdata[7:5]);
                mask_q <= bus_wdata[BIT_MASK];
                dma_q  <= bus_wdata[BIT_DMA];
                svc_q  <= bus_wdata[BIT_SVC];
            end
            if (svc_set) svc_q <= 1'b1;
        end
    end

    ecp_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_fault_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (fault_n),
        .q     (fault_sync)
    );

    ecp_err_irq u_err_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_n    (fault_sync),
        .mask      (mask_q),
        .irq_pulse (irq_pulse)
    );

    ecp_index_regs u_index (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_wr     (idx_wr),
        .data_wr    (data_wr),
        .wdata      (bus_wdata),
        .idx_q      (idx_q),
        .data_rdata (data_rdata)
    );

    // Read mux (combinational; bus_rd qualifies the sample point only).
    always_comb begin
        bus_rdata = 8'h00;
        unique case (sel)
            SEL_CTRL: bus_rdata = {mode_q, mask_q, dma_q, svc_q, 2'b00};
            SEL_IDX:  bus_rdata = cfg_en ? {5'b0, idx_q} : 8'h00;
            SEL_DATA: bus_rdata = cfg_en ? data_rdata : 8'h00;
            SEL_NONE: bus_rdata = 8'h00;
        endcase
    end

    assign mode       = mode_q;
    assign dma_req_oe = dma_q;
    assign dma_req    = dma_q && !svc_q;

    // R8
    dma_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_req_oe |-> !dma_req);

    // R3
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 3'b101);

    // R13
    idx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(idx_q));

    // R9
    svc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_set |=> (svc_q && !dma_req));

    // R10
    idx_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_IDX) |-> (bus_rdata[7:3] == 5'b0));

    // R4
    ctrl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_CTRL) |-> (bus_rdata[1:0] == 2'b00));

    // R13
    data_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !cfg_en && sel != SEL_CTRL) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/test_ecp_ctrl_regs.sv
module test_ecp_ctrl_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cfg_en = 1'b0;
    logic       fault_n = 1'b1;
    logic       svc_set = 1'b0;
    logic       dma_req, dma_req_oe, irq_pulse;
    logic [2:0] mode;

    int checks = 0;
    int failures = 0;
    int irq_cnt = 0;
    int width_err = 0;
    logic irq_prev = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    ecp_ctrl_regs i_ecp_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_en(cfg_en), .fault_n(fault_n), .svc_set(svc_set),
        .dma_req(dma_req), .dma_req_oe(dma_req_oe), .irq_pulse(irq_pulse),
        .mode(mode)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read data and compares.
    always @(negedge clk) begin
        if (bus_rd) begin
            if (exp_q.size() == 0) chk("monitor-underflow", 8'h01, 8'h00);
            else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
        if (irq_pulse) irq_cnt++;
        if (irq_pulse && irq_prev) width_err++;
        irq_prev = irq_pulse;
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(2'd0, 8'h00, "R1 ctrl reset");
        chk("R1 mode reset", {5'b0, mode}, 8'h00);
        chk("R1 dma reset", {6'b0, dma_req_oe, dma_req}, 8'h00);
        chk("R1 no irq", irq_cnt[7:0], 8'h00);
        cfg_en = 1'b1;
        rd(2'd1, 8'h00, "R1 index reset");
        for (int k = 0; k < 8; k++) begin
            wr(2'd1, 8'(k));
            rd(2'd2, 8'h00, "R1 slot reset");
        end
        // R2 unused address
        rd(2'd3, 8'h00, "R2 address 3 reads zero");

        // R3 mode encodings
        for (int m = 0; m < 8; m++) begin
            if (m != 5) begin
                wr(2'd0, {3'(m), 5'b0});
                chk("R3 mode output", {5'b0, mode}, 8'(m));
                rd(2'd0, {3'(m), 5'b0}, "R3 mode readback");
            end
        end
        wr(2'd0, 8'h60);
        wr(2'd0, 8'hB0);
        chk("R3 reserved mode kept", {5'b0, mode}, 8'h03);
        rd(2'd0, 8'h70, "R3 reserved write other fields");
        // R4
        wr(2'd0, 8'hFF);
        rd(2'd0, 8'hFC, "R4 low bits zero");

        // R8 DMA
        wr(2'd0, 8'h00);
        chk("R8 dma off", {6'b0, dma_req_oe, dma_req}, 8'h00);
        wr(2'd0, 8'h08);
        chk("R8 dma on svc0", {6'b0, dma_req_oe, dma_req}, 8'h03);
        wr(2'd0, 8'h0C);
        chk("R8 dma on svc1", {6'b0, dma_req_oe, dma_req}, 8'h02);
        // R9 service set
        wr(2'd0, 8'h08);
        @(posedge clk); #1; svc_set = 1'b1;
        @(posedge clk); #1; svc_set = 1'b0;
        rd(2'd0, 8'h0C, "R9 svc_set sets bit");
        chk("R9 request dropped", {7'b0, dma_req}, 8'h00);
        wr(2'd0, 8'h08);
        chk("R9 cpu clears svc", {7'b0, dma_req}, 8'h01);

        // R5 falling edge
        wr(2'd0, 8'h00);
        irq_cnt = 0;
        fault_n = 1'b0; idle(8);
        chk("R5 fall pulse count", irq_cnt[7:0], 8'h01);
        fault_n = 1'b1; idle(8);
        chk("R5 rise no pulse", irq_cnt[7:0], 8'h01);
        // R6 masked
        wr(2'd0, 8'h10);
        fault_n = 1'b0; idle(8);
        chk("R6 masked no pulse", irq_cnt[7:0], 8'h01);
        // R7 release while low
        wr(2'd0, 8'h00); idle(6);
        chk("R7 release low pulse", irq_cnt[7:0], 8'h02);
        fault_n = 1'b1; idle(8);
        wr(2'd0, 8'h10);
        wr(2'd0, 8'h00); idle(6);
        chk("R7 release high no pulse", irq_cnt[7:0], 8'h02);
        chk("R5 single-cycle width", width_err[7:0], 8'h00);

        // R10 index
        wr(2'd1, 8'hFD);
        rd(2'd1, 8'h05, "R10 index upper zero");

        // R11 slots
        wr(2'd1, 8'd0); wr(2'd2, 8'h11);
        wr(2'd1, 8'd2); wr(2'd2, 8'h22);
        wr(2'd1, 8'd4); wr(2'd2, 8'h44);
        wr(2'd1, 8'd5); wr(2'd2, 8'h55);
        wr(2'd1, 8'd0); rd(2'd2, 8'h11, "R11 offset 0");
        wr(2'd1, 8'd2); rd(2'd2, 8'h22, "R11 offset 2");
        wr(2'd1, 8'd4); rd(2'd2, 8'h44, "R11 offset 4");
        wr(2'd1, 8'd5); rd(2'd2, 8'h55, "R11 offset 5");

        // R12 unsupported offsets
        wr(2'd1, 8'd1); wr(2'd2, 8'hE1);
        wr(2'd1, 8'd3); wr(2'd2, 8'hE3);
        wr(2'd1, 8'd6); wr(2'd2, 8'hE6);
        wr(2'd1, 8'd7); wr(2'd2, 8'hE7);
        rd(2'd2, 8'h00, "R12 bad offset reads zero");
        wr(2'd1, 8'd0); rd(2'd2, 8'h11, "R12 slot 0 untouched");
        wr(2'd1, 8'd2); rd(2'd2, 8'h22, "R12 slot 2 untouched");
        wr(2'd1, 8'd4); rd(2'd2, 8'h44, "R12 slot 4 untouched");
        wr(2'd1, 8'd5); rd(2'd2, 8'h55, "R12 slot 5 untouched");

        // R13 gating
        cfg_en = 1'b0;
        wr(2'd1, 8'd0);
        wr(2'd2, 8'h99);
        rd(2'd1, 8'h00, "R13 index gated read");
        rd(2'd2, 8'h00, "R13 data gated read");
        cfg_en = 1'b1;
        rd(2'd1, 8'h05, "R13 index kept");
        rd(2'd2, 8'h55, "R13 data kept");

        idle(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule